// File: doc/BRIEF.md
# Per-Warp Hit-Ratio Type Classifier

This block watches the stream of shared-cache lookup results coming back for each warp and keeps two saturating counts for every warp: how many lookups it made and how many of them hit. From those counts it places each warp into one of five divergence classes. The classes are ordered by priority: all-hit ranks highest, then mostly-hit, balanced and mostly-miss, with all-miss lowest. A lookup from a warp that rarely hits gains little from the cache, so warps in the two lowest classes are flagged so that their requests go around it.

Downstream logic presents a warp ID on the query port and reads back that warp's class and the bypass flag, combinationally, in the same cycle. The class comes from the hit ratio (hits divided by accesses). It is found with multiplies against two integer percentage thresholds, so no divider is needed. Bypassed lookups are still reported to the block as misses.

A programmable sampling period clears every warp's counts at once. Classification therefore restarts with each program phase, and a warp that was bypassed can earn its way back.

Top module: `warpcls_top`

## Requirements
- R1: Each cycle with `updValid` high adds one to the access count of warp `updWarp`, and adds one to its hit count when `updHit` is high. A query returns the class computed from the counts held before that cycle's update, including when the query and the update name the same warp. The hit count never exceeds the access count.
- R2: `qryClass` uses this encoding: 0 all-hit, 1 mostly-hit, 2 balanced, 3 mostly-miss, 4 all-miss. No other value appears.
- R3: A warp with at least one access whose hits equal its accesses reports class 0. This takes precedence over every other class.
- R4: A warp with at least one access and zero hits reports class 4.
- R5: Otherwise, a warp with 100·hits ≥ `cfgHighPct`·accesses reports class 1.
- R6: Otherwise, a warp with 100·hits < `cfgLowPct`·accesses reports class 3.
- R7: Any other warp reports class 2. This includes a warp with no accesses in the current interval, whose bypass flag is low.
- R8: `qryBypass` is high exactly when the queried warp's class is 3 or 4.
- R9: Reset clears all counts and the period counter. When `cfgPeriod` is non-zero, every `cfgPeriod`-th cycle after reset or after the previous clear zeroes all warps' counts in one cycle. A lookup in that same cycle counts as the first event of the new interval. A `cfgPeriod` of 0 never clears.
- R10: Both counts saturate at 2^CNT_W − 1 and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgHighPct | input | PCT_W | Mostly-hit threshold, percent |
| cfgLowPct | input | PCT_W | Mostly-miss threshold, percent |
| cfgPeriod | input | PERIOD_W | Sampling period in cycles, 0 disables clearing |
| updValid | input | 1 | A lookup result is present |
| updWarp | input | WID_W | Warp ID of the lookup |
| updHit | input | 1 | Lookup hit in the cache |
| qryWarp | input | WID_W | Warp ID being queried |
| qryClass | output | 3 | Class of the queried warp |
| qryBypass | output | 1 | Queried warp's requests should skip the cache |

## Verification
The following properties are checked on every cycle through the queried warp's counts:
- the class is always a legal code;
- the hit count never exceeds the access count;
- the empty, all-hit and all-miss cases map to their codes;
- the bypass flag matches the class;
- a saturated count stays put;
- a period clear leaves at most one access behind.

The ratio thresholds have to be shown by the bench's scenarios: the exact 70% and 20% boundaries, the same-cycle update-and-query ordering, a lookup landing on the clear cycle, and the interval length itself. For these, a behavioural model is compared with the outputs every cycle.

// File: rtl/warpcls_pkg.sv
package warpcls_pkg;

  typedef enum logic [2:0] {
    CLS_ALL_HIT     = 3'd0,
    CLS_MOSTLY_HIT  = 3'd1,
    CLS_BALANCED    = 3'd2,
    CLS_MOSTLY_MISS = 3'd3,
    CLS_ALL_MISS    = 3'd4
  } warp_class_e;

  typedef struct packed {
    logic clearAll;
    logic bumpAcc;
    logic bumpHit;
  } cls_strobe_t;

endpackage

// File: rtl/warpcls_ctrl.sv
module warpcls_ctrl
  import warpcls_pkg::*;
#(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PERIOD_W-1:0] cfgPeriod,
  input  logic                updValid,
  input  logic                updHit,
  output cls_strobe_t         strobe
);

  logic [PERIOD_W-1:0] cycCnt;
  logic                periodEnd;

  // a period of zero disables clearing; >= tolerates a shrinking period
  always_comb begin
    periodEnd = 1'b0;
    if (cfgPeriod != '0) begin
      periodEnd = (cycCnt >= (cfgPeriod - PERIOD_W'(1)));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycCnt <= '0;
    end else if (periodEnd || (cfgPeriod == '0)) begin
      cycCnt <= '0;
    end else begin
      cycCnt <= cycCnt + PERIOD_W'(1);
    end
  end

  always_comb begin
    strobe.clearAll = periodEnd;
    strobe.bumpAcc  = updValid;
    strobe.bumpHit  = updValid && updHit;
  end

endmodule

// File: rtl/warpcls_dp.sv
module warpcls_dp
  import warpcls_pkg::*;
#(
  parameter int NUM_WARPS = 16,
  parameter int CNT_W     = 10,
  parameter int PCT_W     = 7,
  parameter int WID_W     = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  cls_strobe_t      strobe,
  input  logic [WID_W-1:0] updWarp,
  input  logic [WID_W-1:0] qryWarp,
  input  logic [PCT_W-1:0] cfgHighPct,
  input  logic [PCT_W-1:0] cfgLowPct,
  output warp_class_e      qryClass,
  output logic             qryBypass,
  output logic [CNT_W-1:0] qryAcc,
  output logic [CNT_W-1:0] qryHits
);

  localparam int PROD_W = CNT_W + PCT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [WID_W:0] WARP_LIMIT = (WID_W + 1)'(NUM_WARPS);

  logic [CNT_W-1:0] accCnt [NUM_WARPS];
  logic [CNT_W-1:0] hitCnt [NUM_WARPS];
  logic             updInRange;
  logic             qryInRange;

  assign updInRange = ({1'b0, updWarp} < WARP_LIMIT);
  assign qryInRange = ({1'b0, qryWarp} < WARP_LIMIT);

  // one counter pair per warp; clear wins over old value, update lands on top
  for (genvar w = 0; w < NUM_WARPS; w++) begin : gWarp
    logic hitThis;
    logic [CNT_W-1:0] accBase;
    logic [CNT_W-1:0] hitBase;

    assign hitThis = updInRange && (updWarp == WID_W'(w));
    assign accBase = strobe.clearAll ? '0 : accCnt[w];
    assign hitBase = strobe.clearAll ? '0 : hitCnt[w];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        accCnt[w] <= '0;
        hitCnt[w] <= '0;
      end else begin
        if (hitThis && strobe.bumpAcc && (accBase != CNT_MAX)) begin
          accCnt[w] <= accBase + CNT_W'(1);
        end else begin
          accCnt[w] <= accBase;
        end
        if (hitThis && strobe.bumpHit && (hitBase != CNT_MAX)) begin
          hitCnt[w] <= hitBase + CNT_W'(1);
        end else begin
          hitCnt[w] <= hitBase;
        end
      end
    end
  end

  always_comb begin
    qryAcc  = '0;
    qryHits = '0;
    if (qryInRange) begin
      qryAcc  = accCnt[qryWarp];
      qryHits = hitCnt[qryWarp];
    end
  end

  // ratio tests by cross-multiplication
  logic [PROD_W-1:0] hitsScaled;
  logic [PROD_W-1:0] highScaled;
  logic [PROD_W-1:0] lowScaled;

  assign hitsScaled = PROD_W'(qryHits) * PROD_W'(100);
  assign highScaled = PROD_W'(qryAcc) * PROD_W'(cfgHighPct);
  assign lowScaled  = PROD_W'(qryAcc) * PROD_W'(cfgLowPct);

  always_comb begin
    if (qryAcc == '0) begin
      qryClass = CLS_BALANCED;
    end else if (qryHits == qryAcc) begin
      qryClass = CLS_ALL_HIT;
    end else if (qryHits == '0) begin
      qryClass = CLS_ALL_MISS;
    end else if (hitsScaled >= highScaled) begin
      qryClass = CLS_MOSTLY_HIT;
    end else if (hitsScaled < lowScaled) begin
      qryClass = CLS_MOSTLY_MISS;
    end else begin
      qryClass = CLS_BALANCED;
    end
  end

  assign qryBypass = (qryClass == CLS_MOSTLY_MISS) || (qryClass == CLS_ALL_MISS);

endmodule

// File: rtl/warpcls_top.sv
module warpcls_top
  import warpcls_pkg::*;
#(
  parameter int NUM_WARPS = 16,
  parameter int CNT_W     = 10,
  parameter int PCT_W     = 7,
  parameter int PERIOD_W  = 16,
  parameter int WID_W     = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PCT_W-1:0]    cfgHighPct,
  input  logic [PCT_W-1:0]    cfgLowPct,
  input  logic [PERIOD_W-1:0] cfgPeriod,
  input  logic                updValid,
  input  logic [WID_W-1:0]    updWarp,
  input  logic                updHit,
  input  logic [WID_W-1:0]    qryWarp,
  output logic [2:0]          qryClass,
  output logic                qryBypass
);

  cls_strobe_t      strobe;
  warp_class_e      classOut;
  logic [CNT_W-1:0] qryAcc;
  logic [CNT_W-1:0] qryHits;

  warpcls_ctrl #(.PERIOD_W(PERIOD_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgPeriod (cfgPeriod),
    .updValid  (updValid),
    .updHit    (updHit),
    .strobe    (strobe)
  );

  warpcls_dp #(
    .NUM_WARPS (NUM_WARPS),
    .CNT_W     (CNT_W),
    .PCT_W     (PCT_W),
    .WID_W     (WID_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .updWarp    (updWarp),
    .qryWarp    (qryWarp),
    .cfgHighPct (cfgHighPct),
    .cfgLowPct  (cfgLowPct),
    .qryClass   (classOut),
    .qryBypass  (qryBypass),
    .qryAcc     (qryAcc),
    .qryHits    (qryHits)
  );

  assign qryClass = classOut;

endmodule

// File: rtl/warpcls_chk.sv
module warpcls_chk #(
  parameter int CNT_W = 10,
  parameter int WID_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             clearAll,
  input logic [WID_W-1:0] qryWarp,
  input logic [CNT_W-1:0] qryAcc,
  input logic [CNT_W-1:0] qryHits,
  input logic [2:0]       qryClass,
  input logic             qryBypass
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assert_class_legal_R2: assert property (@(posedge clk) disable iff (!rstN)
    qryClass <= 3'd4);

  assert_hits_bounded_R1: assert property (@(posedge clk) disable iff (!rstN)
    qryHits <= qryAcc);

  assert_all_hit_R3: assert property (@(posedge clk) disable iff (!rstN)
    (qryAcc != '0 && qryHits == qryAcc) |-> qryClass == 3'd0);

  assert_all_miss_R4: assert property (@(posedge clk) disable iff (!rstN)
    (qryAcc != '0 && qryHits == '0) |-> qryClass == 3'd4);

  assert_empty_balanced_R7: assert property (@(posedge clk) disable iff (!rstN)
    (qryAcc == '0) |-> (qryClass == 3'd2 && !qryBypass));

  assert_bypass_class_R8: assert property (@(posedge clk) disable iff (!rstN)
    qryBypass == (qryClass == 3'd3 || qryClass == 3'd4));

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rstN)
    clearAll |=> qryAcc <= CNT_W'(1));

  assert_sat_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (qryAcc == CNT_MAX && !clearAll) |=> (!$stable(qryWarp) || qryAcc == CNT_MAX));

endmodule

bind warpcls_top warpcls_chk #(.CNT_W(CNT_W), .WID_W(WID_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .clearAll  (strobe.clearAll),
  .qryWarp   (qryWarp),
  .qryAcc    (qryAcc),
  .qryHits   (qryHits),
  .qryClass  (qryClass),
  .qryBypass (qryBypass)
);

// File: tb/tb_warpcls_top.sv
module tb_warpcls_top;

  localparam int NW    = 16;
  localparam int CW    = 4;
  localparam int PW    = 7;
  localparam int PRW   = 16;
  localparam int WW    = 4;
  localparam int MAXC  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [PW-1:0] cfgHighPct = 7'd70;
  logic [PW-1:0] cfgLowPct = 7'd20;
  logic [PRW-1:0] cfgPeriod = '0;
  logic          updValid = 1'b0;
  logic [WW-1:0] updWarp = '0;
  logic          updHit = 1'b0;
  logic [WW-1:0] qryWarp = '0;
  logic [2:0]    qryClass;
  logic          qryBypass;

  int accM [NW];
  int hitM [NW];
  int cycM;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  warpcls_top #(.NUM_WARPS(NW), .CNT_W(CW), .PCT_W(PW), .PERIOD_W(PRW)) dut (
    .clk(clk), .rstN(rstN), .cfgHighPct(cfgHighPct), .cfgLowPct(cfgLowPct),
    .cfgPeriod(cfgPeriod), .updValid(updValid), .updWarp(updWarp),
    .updHit(updHit), .qryWarp(qryWarp), .qryClass(qryClass), .qryBypass(qryBypass)
  );

  function automatic int expClass(int w);
    int a = accM[w];
    int h = hitM[w];
    if (a == 0) return 2;
    if (h == a) return 0;
    if (h == 0) return 4;
    if (h * 100 >= a * int'(cfgHighPct)) return 1;
    if (h * 100 < a * int'(cfgLowPct)) return 3;
    return 2;
  endfunction

  function automatic string tagOf(int c);
    case (c)
      0: return "R3";
      1: return "R5";
      3: return "R6";
      4: return "R4";
      default: return "R7";
    endcase
  endfunction

  task automatic compare(string ctx);
    int ec = expClass(int'(qryWarp));
    bit eb = (ec == 3 || ec == 4);
    checks++;
    if (int'(qryClass) != ec) begin
      fails++;
      $display("FAIL %s/R2 %s warp %0d class got %0d exp %0d", tagOf(ec), ctx,
               qryWarp, qryClass, ec);
    end else if (qryBypass != eb) begin
      fails++;
      $display("FAIL R8 %s warp %0d bypass got %0d exp %0d", ctx, qryWarp, qryBypass, eb);
    end
  endtask

  // behavioural model of one clock edge (R1, R9, R10)
  task automatic advance();
    if (cfgPeriod != 0 && cycM >= int'(cfgPeriod) - 1) begin
      foreach (accM[i]) begin accM[i] = 0; hitM[i] = 0; end
      cycM = 0;
    end else if (cfgPeriod == 0) begin
      cycM = 0;
    end else begin
      cycM++;
    end
    if (updValid) begin
      if (accM[updWarp] < MAXC) accM[updWarp]++;
      if (updHit && hitM[updWarp] < MAXC) hitM[updWarp]++;
    end
  endtask

  // called at a falling edge: drive, settle, check, model the edge, wait
  task automatic step(bit v, int w, bit h, int q, string ctx);
    updValid = v; updWarp = WW'(w); updHit = h; qryWarp = WW'(q);
    #1;
    compare(ctx);
    advance();
    @(negedge clk);
  endtask

  task automatic feed(int w, int nHit, int nMiss, string ctx);
    for (int i = 0; i < nHit; i++) step(1'b1, w, 1'b1, w, ctx);
    for (int i = 0; i < nMiss; i++) step(1'b1, w, 1'b0, w, ctx);
  endtask

  initial begin
    foreach (accM[i]) begin accM[i] = 0; hitM[i] = 0; end
    cycM = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R9 reset state and R7 empty warps
    for (int q = 0; q < NW; q++) step(1'b0, 0, 1'b0, q, "reset sweep R9");

    // R1 same-cycle update and query sees old counts
    step(1'b1, 8, 1'b1, 8, "same-cycle R1");
    step(1'b0, 0, 1'b0, 8, "after update R1");

    feed(1, 10, 0, "all-hit R3");
    feed(2, 0, 5, "all-miss R4 R8");
    feed(3, 8, 2, "80pct R5");
    feed(4, 1, 9, "10pct R6 R8");
    feed(5, 5, 5, "50pct R7");
    feed(6, 7, 3, "70pct edge R5");
    feed(7, 2, 8, "20pct edge R7");
    for (int q = 0; q < 9; q++) step(1'b0, 0, 1'b0, q, "class sweep R2");

    // R10 saturation
    feed(9, 20, 0, "sat hits R10");
    feed(9, 0, 3, "sat miss R10");
    feed(10, 3, 20, "sat acc R10");
    step(1'b0, 0, 1'b0, 9, "sat hold R10");
    step(1'b0, 0, 1'b0, 10, "sat hold R10");

    // R9 periodic clear with traffic landing on clear cycles
    cfgPeriod = 16'd12;
    for (int i = 0; i < 60; i++) begin
      step(1'b1, i % 3, (i % 4) != 0, (i + 1) % 3, "period R9");
    end
    cfgPeriod = 16'd5;
    for (int i = 0; i < 30; i++) begin
      step(1'b1, 4, (i % 5) == 0, 4, "short period R9");
    end
    cfgPeriod = 16'd0;
    feed(11, 2, 6, "no clear R9");
    for (int i = 0; i < 40; i++) step(1'b0, 0, 1'b0, 11, "disabled R9");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule